// File: doc/BRIEF.md
# Window Threshold Alert Monitor

This block watches the conversion results of a four-channel converter and raises an out-of-window alarm. Every time the converter signals that a conversion has finished, each channel's result is compared with one upper limit and one lower limit. Both limits are shared by all channels. A channel whose result lies strictly above the upper limit sets its own high flag. A channel whose result lies strictly below the lower limit sets its own low flag.

The eight flags are sticky. They stay set across later in-range conversions until the host reads the status register or a new serial frame begins on a chip-select falling edge. An active-low alert pin summarises the flags and is driven only while the alert enable is set. Register decoding and sharing of the pin with serial data are handled elsewhere. This block receives the 12-bit limit fields, one-cycle strobes and the alert enable as plain inputs.

Top module: `alert_win_mon`

## Requirements
- R1: While reset is asserted (asynchronous, active low), `flag_o` is 0 and `alert_n` is 1.
- R2: On a clock edge with `conv_done` high, if the most significant 12 bits of channel i's result (channel i occupies `chan_result[16*i+15:16*i]`) are greater than `hi_limit`, bit i of `flag_o` is 1 after that edge.
- R3: On a clock edge with `conv_done` high, if the most significant 12 bits of channel i's result are less than `lo_limit`, bit 4+i of `flag_o` is 1 after that edge.
- R4: A result whose top 12 bits equal `hi_limit` or `lo_limit` sets no flag.
- R5: The result bits below the top 12 bits have no effect on any flag.
- R6: A set flag stays set across later conversions whose results are inside the window, provided no clear strobe is present.
- R7: When `conv_done` is low, changes on `chan_result` have no effect, and `flag_o` holds unless a clear strobe is present.
- R8: A `stat_rd` pulse without `conv_done` clears all eight flags at that edge.
- R9: A `cs_fall` pulse without `conv_done` clears all eight flags at that edge.
- R10: When `conv_done` and a clear strobe (`stat_rd` or `cs_fall`) occur in the same cycle, `flag_o` takes exactly the outcome of the new comparison, and older flags are dropped.
- R11: `alert_n` is 0 exactly when `alert_en` is 1 and at least one flag is set. It follows `alert_en` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| chan_result | input | 64 | Four 16-bit results, channel 0 in the low bits |
| hi_limit | input | 12 | Shared upper limit |
| lo_limit | input | 12 | Shared lower limit |
| alert_en | input | 1 | Enables driving of the alert pin |
| cs_fall | input | 1 | One-cycle pulse on a chip-select falling edge |
| stat_rd | input | 1 | One-cycle pulse on a read of the status register |
| flag_o | output | 8 | Bits 3:0 are the high flags of channels 0 to 3; bits 7:4 are the low flags |
| alert_n | output | 1 | Active-low alert |

## Verification
A wrong comparison or a missed update shows on `flag_o` one edge after the conversion strobe. Because the flags are sticky, a flag set in error stays visible until the next clear and is caught by any later sample. A flag that clears when it should hold shows only in the sample taken directly after the faulty edge. For that reason every vector is checked right after its edge. The alert pin is combinational from the flags and the enable, so a fault in its gating shows within the same cycle that `alert_en` changes. The bench checks it that way, without waiting for a clock edge.

// File: rtl/alert_win_pkg.sv
package alert_win_pkg;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_MERGE,
        UPD_CLEAR,
        UPD_RELOAD
    } upd_mode_e;

    // Chooses how the flag register evolves from the strobes of this cycle.
    // A fresh comparison outranks a clear that arrives with it.
    function automatic upd_mode_e pick_mode(input logic upd, input logic clr);
        upd_mode_e m;
        case ({upd, clr})
            2'b10:   m = UPD_MERGE;
            2'b01:   m = UPD_CLEAR;
            2'b11:   m = UPD_RELOAD;
            default: m = UPD_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alert_win_cmp.sv
module alert_win_cmp #(
    parameter int unsigned RES_W = 16,
    parameter int unsigned THR_W = 12
) (
    input  logic [RES_W-1:0] res,
    input  logic [THR_W-1:0] thr_hi,
    input  logic [THR_W-1:0] thr_lo,
    output logic             over,
    output logic             under
);
    // The limit lines up with the top THR_W bits of the result.
    localparam int unsigned SH    = RES_W - THR_W;
    localparam int unsigned CMP_W = RES_W + 1;

    logic [CMP_W-1:0] res_x;
    logic [CMP_W-1:0] hi_bound;
    logic [CMP_W-1:0] lo_bound;

    // top > hi  <=>  res >= (hi+1) << SH ;  top < lo  <=>  res < lo << SH
    always_comb begin
        res_x    = {1'b0, res};
        hi_bound = (CMP_W'(thr_hi) + CMP_W'(1)) << SH;
        lo_bound = CMP_W'(thr_lo) << SH;
        over     = (res_x >= hi_bound);
        under    = (res_x <  lo_bound);
    end

endmodule

// File: rtl/alert_flag_bank.sv
module alert_flag_bank
    import alert_win_pkg::*;
#(
    parameter int unsigned FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              clr,
    input  logic [FLAG_W-1:0] hits,
    output logic [FLAG_W-1:0] flags
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } bank_t;

    bank_t     s_d, s_q;
    upd_mode_e mode_d;

    always_comb begin
        s_d    = s_q;
        mode_d = pick_mode(upd, clr);
        case (mode_d)
            UPD_MERGE:  s_d.flags = s_q.flags | hits;
            UPD_CLEAR:  s_d.flags = '0;
            UPD_RELOAD: s_d.flags = hits;
            default:    s_d.flags = s_q.flags;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags = s_q.flags;

endmodule

// File: rtl/alert_win_mon.sv
module alert_win_mon #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned RES_W  = 16,
    parameter int unsigned THR_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv_done,
    input  logic [NUM_CH*RES_W-1:0] chan_result,
    input  logic [THR_W-1:0]        hi_limit,
    input  logic [THR_W-1:0]        lo_limit,
    input  logic                    alert_en,
    input  logic                    cs_fall,
    input  logic                    stat_rd,
    output logic [2*NUM_CH-1:0]     flag_o,
    output logic                    alert_n
);
    localparam int unsigned FLAG_W = 2 * NUM_CH;

    logic [NUM_CH-1:0] over_v;
    logic [NUM_CH-1:0] under_v;
    logic [FLAG_W-1:0] hits_d;
    logic [FLAG_W-1:0] flags_q;
    logic              clr_d;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        alert_win_cmp #(
            .RES_W (RES_W),
            .THR_W (THR_W)
        ) u_cmp (
            .res    (chan_result[ch*RES_W +: RES_W]),
            .thr_hi (hi_limit),
            .thr_lo (lo_limit),
            .over   (over_v[ch]),
            .under  (under_v[ch])
        );
    end

    always_comb begin
        hits_d  = {under_v, over_v};
        clr_d   = stat_rd | cs_fall;
        alert_n = ~(alert_en & (|flags_q));
    end

    alert_flag_bank #(
        .FLAG_W (FLAG_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (conv_done),
        .clr   (clr_d),
        .hits  (hits_d),
        .flags (flags_q)
    );

    assign flag_o = flags_q;

endmodule

// File: rtl/alert_win_mon_chk.sv
module alert_win_mon_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned RES_W  = 16,
    parameter int unsigned THR_W  = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    conv_done,
    input logic [NUM_CH*RES_W-1:0] chan_result,
    input logic [THR_W-1:0]        hi_limit,
    input logic [THR_W-1:0]        lo_limit,
    input logic                    alert_en,
    input logic                    cs_fall,
    input logic                    stat_rd,
    input logic [2*NUM_CH-1:0]     flag_o,
    input logic                    alert_n
);
    localparam int unsigned SH = RES_W - THR_W;

    logic [NUM_CH-1:0] hi_out;
    logic [NUM_CH-1:0] lo_out;

    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            hi_out[ch] = (RES_W'(chan_result[ch*RES_W +: RES_W] >> SH) > RES_W'(hi_limit));
            lo_out[ch] = (RES_W'(chan_result[ch*RES_W +: RES_W] >> SH) < RES_W'(lo_limit));
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_win
        assert_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
            conv_done && hi_out[ch] |=> flag_o[ch]);
        assert_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            conv_done && lo_out[ch] |=> flag_o[NUM_CH+ch]);
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && !stat_rd && !cs_fall |=> (flag_o & $past(flag_o)) == $past(flag_o));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done && !stat_rd && !cs_fall |=> $stable(flag_o));

    assert_rdclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !conv_done |=> flag_o == '0);

    assert_csclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall && !conv_done |=> flag_o == '0);

    assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && (stat_rd || cs_fall) && hi_out == '0 && lo_out == '0 |=> flag_o == '0);

    assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_en |-> alert_n);

    assert_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alert_en && flag_o != '0 |-> !alert_n);

endmodule

bind alert_win_mon alert_win_mon_chk #(
    .NUM_CH (NUM_CH),
    .RES_W  (RES_W),
    .THR_W  (THR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .chan_result (chan_result),
    .hi_limit    (hi_limit),
    .lo_limit    (lo_limit),
    .alert_en    (alert_en),
    .cs_fall     (cs_fall),
    .stat_rd     (stat_rd),
    .flag_o      (flag_o),
    .alert_n     (alert_n)
);

// File: tb/tb_alert_win_mon.sv
`timescale 1ns/1ps
module tb_alert_win_mon;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [63:0] chan_result = '0;
    logic [11:0] hi_limit = '0;
    logic [11:0] lo_limit = '0;
    logic        alert_en = 1'b0;
    logic        cs_fall = 1'b0;
    logic        stat_rd = 1'b0;
    logic [7:0]  flag_o;
    logic        alert_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alert_win_mon dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .chan_result (chan_result),
        .hi_limit    (hi_limit),
        .lo_limit    (lo_limit),
        .alert_en    (alert_en),
        .cs_fall     (cs_fall),
        .stat_rd     (stat_rd),
        .flag_o      (flag_o),
        .alert_n     (alert_n)
    );

    typedef struct packed {
        logic [63:0] res;
        logic [11:0] hi;
        logic [11:0] lo;
        logic        eoc;
        logic        rd;
        logic        csf;
        logic        en;
        logic [7:0]  st;
        logic        an;
    } vec_t;

    // res fields: {ch3, ch2, ch1, ch0}
    localparam vec_t VECS [10] = '{
        '{64'h5000_5000_5000_5000, 12'h800, 12'h200, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1},
        '{64'h2000_8000_1FF0_8010, 12'h800, 12'h200, 1'b1, 1'b0, 1'b0, 1'b1, 8'h21, 1'b0},
        '{64'h5000_800F_5000_5000, 12'h800, 12'h200, 1'b1, 1'b0, 1'b0, 1'b1, 8'h21, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 12'h800, 12'h200, 1'b0, 1'b0, 1'b0, 1'b0, 8'h21, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 12'h800, 12'h200, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1},
        '{64'hFFF0_5000_A00F_00F0, 12'hA00, 12'h100, 1'b1, 1'b0, 1'b0, 1'b1, 8'h18, 1'b0},
        '{64'h5000_5000_B000_5000, 12'hA00, 12'h100, 1'b1, 1'b0, 1'b1, 1'b1, 8'h02, 1'b0},
        '{64'h5000_5000_5000_5000, 12'hA00, 12'h100, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1},
        '{64'h5000_0050_5000_5000, 12'hA00, 12'h100, 1'b1, 1'b1, 1'b0, 1'b1, 8'h40, 1'b0},
        '{64'h5000_5000_5000_5000, 12'hA00, 12'h100, 1'b1, 1'b0, 1'b0, 1'b0, 8'h40, 1'b1}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R4 all in window";
            1: return "R2 R3 R4 mixed channels";
            2: return "R5 R6 low bits, sticky";
            3: return "R7 no strobe";
            4: return "R8 status read clear";
            5: return "R2 R3 R4 R5 new limits";
            6: return "R10 R9 cs clear with conversion";
            7: return "R9 cs clear";
            8: return "R10 read clear with conversion";
            default: return "R6 R11 disabled alert";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        for (int n = 0; n < 100000; n++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        alert_en = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset flags", flag_o, 8'h00);
        check("R1 reset alert", {7'b0, alert_n}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chan_result = VECS[i].res;
            hi_limit    = VECS[i].hi;
            lo_limit    = VECS[i].lo;
            conv_done   = VECS[i].eoc;
            stat_rd     = VECS[i].rd;
            cs_fall     = VECS[i].csf;
            alert_en    = VECS[i].en;
            @(posedge clk);
            #2;
            check({vec_tag(i), " flags"}, flag_o, VECS[i].st);
            check({vec_tag(i), " R11 alert"}, {7'b0, alert_n}, {7'b0, VECS[i].an});
        end

        // R11: alert follows the enable with no clock edge
        @(negedge clk);
        conv_done = 1'b0;
        stat_rd   = 1'b0;
        cs_fall   = 1'b0;
        alert_en  = 1'b1;
        #1;
        check("R11 enable on", {7'b0, alert_n}, 8'h00);
        alert_en = 1'b0;
        #1;
        check("R11 enable off", {7'b0, alert_n}, 8'h01);
        alert_en = 1'b1;

        // R1: asynchronous reset clears the set flags between edges
        #1;
        rst_n = 1'b0;
        #1;
        check("R1 async reset flags", flag_o, 8'h00);
        check("R1 async reset alert", {7'b0, alert_n}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 at the extremes of the range
        @(negedge clk);
        chan_result = 64'h0000_FFFF_0000_FFFF;
        hi_limit    = 12'hFFE;
        lo_limit    = 12'h001;
        conv_done   = 1'b1;
        @(posedge clk);
        #2;
        check("R2 R3 extremes", flag_o, 8'hA5);
        @(negedge clk);
        conv_done = 1'b0;

        done = 1'b1;
        finish_run();
    end

endmodule